// File: doc/BRIEF.md
# Transmit Line Clock Source Selector

This block decides which clock drives the transmit side of a T1/E1 framer. There are three candidates: a dedicated transmit clock input, the clock recovered from the receive line, and a scaled master clock. The block runs entirely on a fast, free-running reference clock. It samples the dedicated transmit clock through a synchronizer and watches it for activity. A registered 2-bit select code tells an external glitch-free clock switch which candidate to pass.

A 2-bit mode input chooses the policy. In the automatic mode the block uses the dedicated clock while it toggles. It fails over to the recovered clock once that input has been quiet for one channel time, and it returns only after the input has toggled steadily again. The loss-of-transmit-clock flag is computed in every mode. A single status pin carries either this flag or the receive loss-of-sync indication, chosen by a control bit. A further control bit, registered and passed to the master clock multiplexer, picks where the master clock comes from.

The block carries no data stream, so it has no valid/ready interface. Every pin is a plain level in the reference clock domain, except `tx_clk_in`, which is asynchronous.

Top module: `txclk_src_sel`

## Requirements
- R1: While reset is held, and right after it is released, the outputs are as follows: `clk_sel_o` = 2'b00 (dedicated clock), `lotc_o` = 0, `mclk_sel_o` = 0, and `status_o` follows `rx_los_i` whenever `lotc_stat_sel_i` = 0.
- R2: With `mode_i` = 2'b00, `clk_sel_o` is 2'b00 one reference cycle later, whether or not the dedicated clock toggles.
- R3: With `mode_i` = 2'b10, `clk_sel_o` is 2'b10 (scaled master clock) one reference cycle later, and the dedicated clock has no effect on it.
- R4: With `mode_i` = 2'b11, `clk_sel_o` is 2'b01 (recovered clock) one reference cycle later, and the dedicated clock has no effect on it.
- R5: `lotc_o` rises at the clock edge that ends TIMEOUT_CYC consecutive reference cycles in which the synchronized dedicated clock showed no transition. It never rises earlier.
- R6: The cycle after the synchronized dedicated clock shows a transition, `lotc_o` is 0.
- R7: With `mode_i` = 2'b01, a set `lotc_o` makes `clk_sel_o` 2'b01 on the next cycle.
- R8: After a failover in mode 2'b01, `clk_sel_o` returns to 2'b00 only once RECOVER_EDGES further transitions have been seen after the one that cleared `lotc_o`, with no new timeout in between. A quiet gap shorter than the timeout causes no failover.
- R9: `status_o` equals `rx_los_i` when `lotc_stat_sel_i` = 0 and equals `lotc_o` when it is 1.
- R10: `mclk_sel_o` takes the value of `mclk_src_i` one reference cycle later (0 = master clock pin, 1 = system transmit clock pin).
- R11: `lotc_o` is computed in every mode, including those that ignore it for selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock, faster than every candidate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_clk_in | input | 1 | Dedicated transmit clock, sampled asynchronously |
| mode_i | input | 2 | Source policy: 00 fixed dedicated, 01 automatic, 10 master, 11 recovered |
| lotc_stat_sel_i | input | 1 | Status pin function: 0 receive loss of sync, 1 loss of transmit clock |
| mclk_src_i | input | 1 | Master clock source: 0 master clock pin, 1 system transmit clock pin |
| rx_los_i | input | 1 | Receive loss-of-sync indication from the framer |
| clk_sel_o | output | 2 | Registered select code: 00 dedicated, 01 recovered, 10 scaled master |
| lotc_o | output | 1 | Loss-of-transmit-clock flag |
| status_o | output | 1 | Shared status pin |
| mclk_sel_o | output | 1 | Registered master clock source select |

## Verification
The assertions check on every cycle that the fixed modes map to their select codes, and that `lotc_o` rises exactly when a checker-side quiet-cycle count reaches the timeout. They also check that a transition clears the flag, that the automatic mode fails over as soon as the flag is set, and that the master source bit is registered. Some behaviours only the bench scenarios can show. These are the hysteresis of the return from failover and the rejection of a quiet gap shorter than the timeout. The shared status pin tracking each source as the select bit and `rx_los_i` change is also shown only by the bench.

// File: rtl/txclk_pkg.sv
package txclk_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED = 2'b00,
    MODE_AUTO  = 2'b01,
    MODE_MCLK  = 2'b10,
    MODE_RECOV = 2'b11
  } tx_mode_e;

  typedef enum logic [1:0] {
    SEL_TXIN  = 2'b00,
    SEL_RECOV = 2'b01,
    SEL_MCLK  = 2'b10
  } clk_sel_e;
endpackage

// File: rtl/txclk_edge_sync.sv
module txclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic edge_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], async_i};
  end

  assign edge_o = pipe[STAGES] ^ pipe[STAGES-1];
endmodule

// File: rtl/txclk_act_mon.sv
module txclk_act_mon #(
  parameter int TIMEOUT_CYC = 1036
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic lotc_o
);
  localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] idle_q;
  logic          lotc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      lotc_q <= 1'b0;
    end else if (edge_i) begin
      idle_q <= '0;
      lotc_q <= 1'b0;
    end else begin
      if (idle_q != LAST) idle_q <= idle_q + 1'b1;
      if (idle_q == LAST) lotc_q <= 1'b1;
    end
  end

  assign lotc_o = lotc_q;
endmodule

// File: rtl/txclk_sel_ctrl.sv
module txclk_sel_ctrl
  import txclk_pkg::*;
#(
  parameter int RECOVER_EDGES = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  tx_mode_e mode_i,
  input  logic     lotc_i,
  input  logic     edge_i,
  output clk_sel_e sel_o
);
  localparam int RW = (RECOVER_EDGES > 2) ? $clog2(RECOVER_EDGES) : 1;
  localparam logic [RW-1:0] GOOD_LAST = RW'(RECOVER_EDGES - 1);

  logic          fail_q, fail_d;
  logic [RW-1:0] good_q, good_d;
  clk_sel_e      sel_q,  sel_d;

  always_comb begin
    fail_d = fail_q;
    good_d = good_q;
    if (mode_i != MODE_AUTO) begin
      fail_d = 1'b0;
      good_d = '0;
    end else if (lotc_i) begin
      fail_d = 1'b1;
      good_d = '0;
    end else if (fail_q && edge_i) begin
      if (good_q == GOOD_LAST) begin
        fail_d = 1'b0;
        good_d = '0;
      end else begin
        good_d = good_q + 1'b1;
      end
    end

    case (mode_i)
      MODE_FIXED: sel_d = SEL_TXIN;
      MODE_AUTO:  sel_d = fail_d ? SEL_RECOV : SEL_TXIN;
      MODE_MCLK:  sel_d = SEL_MCLK;
      default:    sel_d = SEL_RECOV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      good_q <= '0;
      sel_q  <= SEL_TXIN;
    end else begin
      fail_q <= fail_d;
      good_q <= good_d;
      sel_q  <= sel_d;
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/txclk_src_sel.sv
module txclk_src_sel
  import txclk_pkg::*;
#(
  parameter int TIMEOUT_CYC   = 1036,
  parameter int RECOVER_EDGES = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       tx_clk_in,
  input  logic [1:0] mode_i,
  input  logic       lotc_stat_sel_i,
  input  logic       mclk_src_i,
  input  logic       rx_los_i,
  output logic [1:0] clk_sel_o,
  output logic       lotc_o,
  output logic       status_o,
  output logic       mclk_sel_o
);
  logic     tx_edge;
  logic     lotc;
  clk_sel_e sel;
  logic     mclk_sel_q;

  txclk_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk_ref), .rst_n(rst_n), .async_i(tx_clk_in), .edge_o(tx_edge)
  );

  txclk_act_mon #(.TIMEOUT_CYC(TIMEOUT_CYC)) mon_i (
    .clk(clk_ref), .rst_n(rst_n), .edge_i(tx_edge), .lotc_o(lotc)
  );

  txclk_sel_ctrl #(.RECOVER_EDGES(RECOVER_EDGES)) ctrl_i (
    .clk(clk_ref), .rst_n(rst_n), .mode_i(tx_mode_e'(mode_i)),
    .lotc_i(lotc), .edge_i(tx_edge), .sel_o(sel)
  );

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) mclk_sel_q <= 1'b0;
    else        mclk_sel_q <= mclk_src_i;
  end

  assign clk_sel_o  = sel;
  assign lotc_o     = lotc;
  assign status_o   = lotc_stat_sel_i ? lotc : rx_los_i;
  assign mclk_sel_o = mclk_sel_q;
endmodule

// File: rtl/txclk_src_sel_chk.sv
module txclk_src_sel_chk #(
  parameter int TIMEOUT_CYC = 1036
) (
  input logic       clk_ref,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       mclk_src_i,
  input logic       edge_i,
  input logic [1:0] clk_sel_o,
  input logic       lotc_o,
  input logic       mclk_sel_o
);
  localparam int KW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [KW-1:0] KMAX = KW'(TIMEOUT_CYC);

  logic [KW-1:0] quiet_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)               quiet_q <= '0;
    else if (edge_i)          quiet_q <= '0;
    else if (quiet_q != KMAX) quiet_q <= quiet_q + 1'b1;
  end

  a_r2_fixed_mode: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode_i == 2'b00) |=> (clk_sel_o == 2'b00));
  a_r3_master_mode: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode_i == 2'b10) |=> (clk_sel_o == 2'b10));
  a_r4_recovered_mode: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode_i == 2'b11) |=> (clk_sel_o == 2'b01));
  a_r5_lotc_at_timeout: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (quiet_q == KMAX) |-> lotc_o);
  a_r5_lotc_not_early: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(lotc_o) |-> (quiet_q == KMAX));
  a_r6_edge_clears: assert property (@(posedge clk_ref) disable iff (!rst_n)
    edge_i |=> !lotc_o);
  a_r7_failover: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode_i == 2'b01 && lotc_o) |=> (clk_sel_o == 2'b01));
  a_r10_mclk_reg: assert property (@(posedge clk_ref) disable iff (!rst_n)
    mclk_src_i |=> mclk_sel_o);
  a_r10_mclk_reg_low: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !mclk_src_i |=> !mclk_sel_o);
endmodule

bind txclk_src_sel txclk_src_sel_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) chk_i (
  .clk_ref(clk_ref), .rst_n(rst_n), .mode_i(mode_i), .mclk_src_i(mclk_src_i),
  .edge_i(tx_edge), .clk_sel_o(clk_sel_o), .lotc_o(lotc_o), .mclk_sel_o(mclk_sel_o)
);

// File: tb/txclk_src_sel_tb.sv
`timescale 1ns/1ps
module txclk_src_sel_tb_top;
  localparam int T_OUT = 100;
  localparam int N_REC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_clk = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       stat_sel = 1'b0;
  logic       mclk_src = 1'b0;
  logic       rx_los = 1'b0;
  logic [1:0] sel;
  logic       lotc, status, mclk_sel;

  int n_cmp = 0;
  int n_bad = 0;
  int tx_half = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  txclk_src_sel #(.TIMEOUT_CYC(T_OUT), .RECOVER_EDGES(N_REC)) dut_i (
    .clk_ref(clk), .rst_n(rst_n), .tx_clk_in(tx_clk), .mode_i(mode),
    .lotc_stat_sel_i(stat_sel), .mclk_src_i(mclk_src), .rx_los_i(rx_los),
    .clk_sel_o(sel), .lotc_o(lotc), .status_o(status), .mclk_sel_o(mclk_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // dedicated transmit clock generator, half period in reference cycles (0 = stopped)
  initial begin
    int tcnt = 0;
    forever begin
      @(negedge clk);
      if (tx_half > 0) begin
        tcnt++;
        if (tcnt >= tx_half) begin tx_clk = ~tx_clk; tcnt = 0; end
      end else tcnt = 0;
    end
  end

  // behavioural reference model
  int hist[$];
  int m_idle = 0, m_lotc = 0, m_fail = 0, m_good = 0, m_sel = 0, m_mclk = 0;

  initial begin
    hist = '{0, 0, 0};
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        hist = '{0, 0, 0};
        m_idle = 0; m_lotc = 0; m_fail = 0; m_good = 0; m_sel = 0; m_mclk = 0;
      end else begin
        bit e;
        int n_idle, n_lotc, n_fail, n_good;
        e = (hist[1] != hist[2]);
        n_idle = e ? 0 : ((m_idle < T_OUT - 1) ? m_idle + 1 : m_idle);
        n_lotc = e ? 0 : ((m_idle == T_OUT - 1) ? 1 : m_lotc);
        n_fail = m_fail; n_good = m_good;
        if (mode != 2'b01) begin n_fail = 0; n_good = 0; end
        else if (m_lotc == 1) begin n_fail = 1; n_good = 0; end
        else if (m_fail == 1 && e) begin
          if (m_good + 1 >= N_REC) begin n_fail = 0; n_good = 0; end
          else n_good = m_good + 1;
        end
        case (mode)
          2'b00: m_sel = 0;
          2'b01: m_sel = n_fail ? 1 : 0;
          2'b10: m_sel = 2;
          default: m_sel = 1;
        endcase
        m_idle = n_idle; m_lotc = n_lotc; m_fail = n_fail; m_good = n_good;
        m_mclk = mclk_src;
        void'(hist.pop_back());
        hist.push_front(int'(tx_clk));
      end
      #1;
      if (!done) begin
        chk("R2 R3 R4 R7 R8 select code", sel, m_sel);
        chk("R5 R6 R11 lotc flag", lotc, m_lotc);
        chk("R9 status pin", status, stat_sel ? m_lotc : int'(rx_los));
        chk("R10 master source", mclk_sel, m_mclk);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    chk("R1 sel in reset", sel, 0);
    chk("R1 lotc in reset", lotc, 0);
    chk("R1 mclk sel in reset", mclk_sel, 0);
    rx_los = 1'b1; wait_cyc(1);
    chk("R1 status shows rx loss of sync", status, 1);
    rx_los = 1'b0;
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1 sel after reset", sel, 0);

    // fixed mode: dedicated clock running, then stopped
    tx_half = 3; wait_cyc(50);
    chk("R2 running", sel, 0);
    chk("R6 no loss while running", lotc, 0);
    tx_half = 0; wait_cyc(2 * T_OUT);
    chk("R5 loss after timeout", lotc, 1);
    chk("R2 stopped clock keeps dedicated", sel, 0);
    stat_sel = 1'b1; wait_cyc(1);
    chk("R9 status shows lotc", status, 1);
    rx_los = 1'b1; wait_cyc(1);
    stat_sel = 1'b0; wait_cyc(1);
    chk("R9 status shows rx los", status, 1);
    rx_los = 1'b0; wait_cyc(1);
    chk("R9 status follows rx los low", status, 0);
    tx_half = 3; wait_cyc(20);
    chk("R6 cleared by transition", lotc, 0);

    // automatic mode: short gap, then failover and hysteretic return
    mode = 2'b01; wait_cyc(30);
    chk("R8 auto mode on dedicated", sel, 0);
    tx_half = 0; wait_cyc(T_OUT / 2);
    tx_half = 3; wait_cyc(30);
    chk("R8 short gap no failover", sel, 0);
    tx_half = 0; wait_cyc(2 * T_OUT);
    chk("R7 failover to recovered", sel, 1);
    tx_half = 3; wait_cyc(12);
    chk("R6 lotc cleared after restart", lotc, 0);
    chk("R8 still recovered during hysteresis", sel, 1);
    wait_cyc(80);
    chk("R8 returned to dedicated", sel, 0);

    // master and recovered modes ignore the dedicated clock
    mode = 2'b10; tx_half = 0; wait_cyc(2 * T_OUT);
    chk("R3 master mode", sel, 2);
    chk("R11 lotc computed in master mode", lotc, 1);
    mode = 2'b11; tx_half = 3; wait_cyc(40);
    chk("R4 recovered mode", sel, 1);
    chk("R11 lotc cleared in recovered mode", lotc, 0);

    // master clock source bit
    mclk_src = 1'b1; wait_cyc(2);
    chk("R10 system clock selected", mclk_sel, 1);
    mclk_src = 1'b0; wait_cyc(2);
    chk("R10 master pin selected", mclk_sel, 0);

    wait_cyc(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule